// File: doc/BRIEF.md
# Backup Source Selector with Isolation

This block decides which energy source feeds the memory supply rail: the main supply, a first backup cell, or a second backup cell. It works on digitized comparator flags. One flag says whether the main supply is above the switch-over level, which is the level of the active cell. Another says whether the main supply is above the power-fail threshold. Each cell has a flag that says whether it is above 2.5 V. A pulse marks a battery attach. Two window-comparator flags watch the chip-enable pin. The block drives a one-hot source select and an isolated indicator. The analog switches that act on the select are outside the block.

While the main supply is up, the rail follows it. When the main supply drops below the switch-over level, the block moves to the first cell, and falls over to the second cell if the first one sags. It stays on the second cell until the main supply returns.

An isolated state keeps the cells off the rail when nothing needs to be retained. A battery attach enters this state. A deliberate request during power-down also enters it. For the request, the chip-enable pin is held near half supply for a set number of consecutive clock cycles while the supply falls between the fail threshold and the switch-over level. The next power-up leaves the isolated state.

Top module: `bkup_src_sel`

## Requirements
- R1: `src_sel` is always one-hot. Bit 0 is main supply, bit 1 is cell 1, bit 2 is cell 2, bit 3 is no source. Outputs are registered, so they reflect the inputs sampled one clock earlier.
- R2: Whenever `main_ok_so` is 1, `src_sel` selects the main supply on the next cycle.
- R3: In backup (`main_ok_so` 0, not isolated), cell 1 is selected while `cell1_ok` is 1 and no fallover has happened in the current backup episode.
- R4: When `cell1_ok` is 0 during backup, the block selects cell 2. It stays on cell 2 (or no source) for the rest of the episode, even if `cell1_ok` returns to 1. Only a return of the main supply ends this.
- R5: In backup, if the chosen cell's flag is 0, `src_sel` shows no source. A cell whose input is unused reads 0 and is therefore never selected.
- R6: A pulse on `batt_attach` sets `isolated` on the next cycle. While isolated and in backup, `src_sel` shows no source.
- R7: Isolation is sealed at the falling edge of `main_ok_so` only under two conditions. First, `ce_mid` was 1 for at least `HOLD_CYCLES` consecutive cycles. Second, those cycles fell within the interval where `main_ok_pf` is 0 and `main_ok_so` is 1. Leaving the window resets the count.
- R8: A cycle with `ce_high` at 1 anywhere inside that interval cancels the request, even after the hold was met.
- R9: A rising edge of `main_ok_so` clears `isolated`. In the following backup episode the cells connect normally.
- R10: After reset, `isolated` is 1 and `src_sel` shows no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_ok_so | input | 1 | Main supply above the switch-over level |
| main_ok_pf | input | 1 | Main supply above the power-fail threshold |
| cell1_ok | input | 1 | Cell 1 above 2.5 V |
| cell2_ok | input | 1 | Cell 2 above 2.5 V |
| batt_attach | input | 1 | Battery attach event pulse |
| ce_mid | input | 1 | Chip-enable inside the mid-supply window |
| ce_high | input | 1 | Chip-enable above the cancel level |
| src_sel | output | 4 | One-hot source select {none, cell2, cell1, main} |
| isolated | output | 1 | Cells held off the rail |

## Verification
The hardest condition to reach from the ports is a sealed isolation. It needs a power-down in which the fail flag drops first. The mid-window flag must then be held for the full run of consecutive cycles before the switch-over flag falls. The stimulus walks this sequence directly. It repeats it with a run one cycle short, with a run broken in the middle, and with a single high-level cycle after a full run. This shows that only the exact qualifying pattern isolates the cells.

// File: rtl/bkup_src_sel.sv
module bkup_src_sel #(
  parameter int HOLD_CYCLES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok_so,
  input  logic       main_ok_pf,
  input  logic       cell1_ok,
  input  logic       cell2_ok,
  input  logic       batt_attach,
  input  logic       ce_mid,
  input  logic       ce_high,
  output logic [3:0] src_sel,
  output logic       isolated
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [3:0] SEL_MAIN = 4'b0001;
  localparam logic [3:0] SEL_C1   = 4'b0010;
  localparam logic [3:0] SEL_C2   = 4'b0100;
  localparam logic [3:0] SEL_NONE = 4'b1000;

  logic          so_q, use2, qual, cancel;
  logic [CW-1:0] hold_cnt;

  wire win      = main_ok_so & ~main_ok_pf;
  wire so_rise  = main_ok_so & ~so_q;
  wire so_fall  = ~main_ok_so & so_q;
  wire seal     = so_fall & qual & ~cancel;
  wire hold_hit = win & ce_mid & (hold_cnt == CW'(HOLD_CYCLES - 1));

  logic iso_n, use2_n;
  logic [3:0] sel_n;

  always_comb begin
    iso_n = batt_attach | seal | (isolated & ~so_rise);
    if (main_ok_so)                   use2_n = 1'b0;
    else if (!iso_n && !cell1_ok)     use2_n = 1'b1;
    else                              use2_n = use2;
    if (main_ok_so)                   sel_n = SEL_MAIN;
    else if (iso_n)                   sel_n = SEL_NONE;
    else if (use2_n)                  sel_n = cell2_ok ? SEL_C2 : SEL_NONE;
    else                              sel_n = SEL_C1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q     <= 1'b0;
      use2     <= 1'b0;
      isolated <= 1'b1;
      src_sel  <= SEL_NONE;
    end else begin
      so_q     <= main_ok_so;
      use2     <= use2_n;
      isolated <= iso_n;
      src_sel  <= sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      qual     <= 1'b0;
      cancel   <= 1'b0;
    end else if (!win) begin
      hold_cnt <= '0;
      qual     <= 1'b0;
      cancel   <= 1'b0;
    end else begin
      if (!ce_mid)                               hold_cnt <= '0;
      else if (hold_cnt != CW'(HOLD_CYCLES))     hold_cnt <= hold_cnt + 1'b1;
      qual   <= qual | hold_hit;
      cancel <= cancel | ce_high;
    end
  end
endmodule

module bkup_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_ok_so,
  input logic       cell1_ok,
  input logic       batt_attach,
  input logic [3:0] src_sel,
  input logic       isolated
);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_sel) == 1);
  assert_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    main_ok_so |=> src_sel == 4'b0001);
  assert_no_c1_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ok_so && !cell1_ok) |=> src_sel != 4'b0010);
  assert_sticky_c2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 4'b0100 && !main_ok_so) |=> src_sel != 4'b0010);
  assert_attach_R6: assert property (@(posedge clk) disable iff (!rst_n)
    batt_attach |=> isolated);
  assert_iso_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isolated && !main_ok_so) |=> src_sel == 4'b1000);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isolated) |-> $past(main_ok_so));
endmodule

bind bkup_src_sel bkup_src_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .main_ok_so(main_ok_so), .cell1_ok(cell1_ok),
  .batt_attach(batt_attach), .src_sel(src_sel), .isolated(isolated)
);

// File: tb/bkup_src_sel_tb.sv
module bkup_src_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam logic [3:0] M = 4'b0001, C1 = 4'b0010, C2 = 4'b0100, NO = 4'b1000;

  logic clk = 0, rst_n = 0;
  logic so = 0, pf = 0, c1 = 0, c2 = 0, att = 0, mid = 0, hi = 0;
  logic [3:0] src_sel;
  logic isolated;
  int checks = 0, errors = 0;

  bkup_src_sel #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .main_ok_so(so), .main_ok_pf(pf),
    .cell1_ok(c1), .cell2_ok(c2), .batt_attach(att), .ce_mid(mid),
    .ce_high(hi), .src_sel(src_sel), .isolated(isolated));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {so,pf,c1,c2,att,mid,hi, sel[3:0], iso}
  localparam logic [11:0] VEC [16] = '{
    {7'b1111000, M,  1'b0},  // R9 power-up clears isolation
    {7'b1111000, M,  1'b0},  // R2
    {7'b1011000, M,  1'b0},  // R2 window, no request
    {7'b0011000, C1, 1'b0},  // R3
    {7'b0011000, C1, 1'b0},  // R3
    {7'b0001000, C2, 1'b0},  // R4 fallover
    {7'b0011000, C2, 1'b0},  // R4 sticky
    {7'b0000000, NO, 1'b0},  // R5
    {7'b0010000, NO, 1'b0},  // R4 R5
    {7'b1011000, M,  1'b0},  // R2
    {7'b1111000, M,  1'b0},  // R2
    {7'b0011000, C1, 1'b0},  // R4 cleared by main
    {7'b1101000, M,  1'b0},  // R2
    {7'b0001000, C2, 1'b0},  // R5 cell1 unused
    {7'b0000000, NO, 1'b0},  // R5 both unused
    {7'b1100000, M,  1'b0}   // R2
  };

  task automatic check(input string req, input logic [3:0] es, input logic ei);
    checks++;
    if (src_sel !== es || isolated !== ei) begin
      errors++;
      $display("FAIL %s: sel=%b iso=%b expected sel=%b iso=%b", req, src_sel, isolated, es, ei);
    end
  endtask

  task automatic step(input logic [6:0] v);
    {so, pf, c1, c2, att, mid, hi} = v;
    @(negedge clk);
  endtask

  task automatic window(input int n, input logic h);
    for (int k = 0; k < n; k++) step({5'b10110, 1'b1, h});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R10 reset", NO, 1'b1);
    rst_n = 1;
    step(7'b0011000);
    check("R10 held until main applied", NO, 1'b1);

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][11:5]);
      check($sformatf("R1 table row %0d", i), VEC[i][4:1], VEC[i][0]);
    end

    // R7 full hold seals
    step(7'b1111000);
    window(HOLD, 1'b0);
    step(7'b1011000);
    step(7'b0011000);
    check("R7 sealed", NO, 1'b1);
    step(7'b0011000);
    check("R7 stays isolated", NO, 1'b1);
    // R9 cleared then reconnects
    step(7'b1111000);
    check("R9 cleared", M, 1'b0);
    step(7'b0011000);
    check("R9 cell reconnects", C1, 1'b0);

    // R7 one cycle short
    step(7'b1111000);
    window(HOLD - 1, 1'b0);
    step(7'b0011000);
    check("R7 short hold", C1, 1'b0);

    // R7 broken run
    step(7'b1111000);
    window(2, 1'b0);
    step(7'b1011000);
    window(2, 1'b0);
    step(7'b0011000);
    check("R7 count resets", C1, 1'b0);

    // R8 cancel after full hold
    step(7'b1111000);
    window(HOLD, 1'b0);
    step(7'b1011001);
    step(7'b0011000);
    check("R8 cancelled", C1, 1'b0);

    // R6 attach during backup
    step(7'b0011100);
    check("R6 attach", NO, 1'b1);
    step(7'b0011000);
    check("R6 stays none", NO, 1'b1);
    step(7'b1111000);
    check("R9 power-up after attach", M, 1'b0);

    // R6 attach with main up
    step(7'b1111100);
    check("R6 attach main up", M, 1'b1);
    step(7'b0011000);
    check("R6 backup isolated", NO, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule